// File: doc/BRIEF.md
# Dot-Matrix Display Host Write Front End

This block is the host-facing register file of an eight-digit dot-matrix display controller. A host processor drives an 8-bit data bus, five address lines, an active-low area-select line, an active-low chip enable and an active-low write strobe, with no regard for the controller's clock. The block brings these signals into the system clock domain and detects the end of each write strobe. It then steers the data into one of five storage areas:

- a per-digit blink bit,
- a pointer that selects a custom glyph,
- the rows of the custom glyph store,
- an eight-entry character memory,
- a control byte.

All stored state is presented on plain output ports to a separate scan engine. The scan engine reads the custom glyph rows through a small combinational read port.

After reset the block ignores the host until the display timebase has produced a fixed number of ticks. Writing the control byte with its clear bit set blanks the whole character memory in the same cycle.

Top module: `dispwr_front`

## Requirements
- R1: A write takes effect only if `host_ce_n` is low when the rising edge of `host_wr_n` is detected. A strobe given with `host_ce_n` high changes no stored state.
- R2: With `host_sel_n` low, a write sets the blink bit of digit `host_addr[2:0]` to `host_data[0]`. `host_addr[4:3]` and the other data bits are ignored. The blink bit of digit d appears at `flash_bits[d]`.
- R3: With `host_sel_n` high and `host_addr[4:3]` = 00, a write loads `host_data[3:0]` into the glyph pointer `udc_ptr`.
- R4: With `host_sel_n` high and `host_addr[4:3]` = 01, a write stores `host_data[4:0]` as row `host_addr[2:0]` of the glyph selected by `udc_ptr`. Only rows 0 to 6 exist, so a write to row 7 is dropped.
- R5: With `host_sel_n` high and `host_addr[4:3]` = 11, a write stores `host_data[7:0]` as the entry of digit `host_addr[2:0]`. Digit 0 is leftmost. Digit d appears at `char_flat[8d+7:8d]`. Bit 7 of an entry marks a glyph index in bits 3:0 (1) or a 7-bit ASCII code in bits 6:0 (0).
- R6: With `host_sel_n` high and `host_addr[4:3]` = 10, a write loads `host_data[7:0]` into `ctrl_word`.
- R7: A control write with bit 7 set also sets all eight character entries to 0x20 (blank) in the same cycle. `ctrl_word` still takes the written byte, and the blink bits and glyph rows keep their contents.
- R8: While `rst` is high, the outputs are cleared as follows:
  - `flash_bits` to 0,
  - `ctrl_word` to 0 (full brightness),
  - `udc_ptr` to 0,
  - every character entry to 0x20.
- R9: After `rst` falls, every write is ignored until three `disp_tick` pulses have been seen. Writes made after the third pulse are accepted.
- R10: `scan_udc_bits` returns the row `scan_udc_row` of glyph `scan_udc_char`, and reads 0 for row 7. The glyph store keeps its contents through reset and through the clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_tick | input | 1 | One-cycle pulse per display timebase period |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_wr_n | input | 1 | Host write strobe, active low, data taken at its rising edge |
| host_sel_n | input | 1 | Area select, low picks the blink bits |
| host_addr | input | 5 | Host address |
| host_data | input | 8 | Host write data |
| scan_udc_char | input | 4 | Glyph index for the scan read port |
| scan_udc_row | input | 3 | Row index for the scan read port |
| flash_bits | output | 8 | Blink bit per digit |
| char_flat | output | 64 | Character entries, digit d at bits 8d+7:8d |
| udc_ptr | output | 4 | Current glyph pointer |
| ctrl_word | output | 8 | Control byte |
| scan_udc_bits | output | 5 | Glyph row selected by the scan read port |

## Verification
The bench builds the block with its default parameters: a two-stage input synchronizer and a three-tick access lockout. With these values the bench can count the lockout exactly, by issuing writes after zero, two and three ticks. The small glyph store lets the read port check every written row, including the missing row 7, across pointer changes, a clear command and a second reset.

// File: rtl/dispwr_pkg.sv
package dispwr_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int DIGITS    = 8;
    localparam int DIG_AW    = $clog2(DIGITS);
    localparam int UDC_CHARS = 16;
    localparam int UDC_AW    = $clog2(UDC_CHARS);
    localparam int UDC_ROWS  = 7;
    localparam int ROW_AW    = 3;
    localparam int ROW_W     = 5;
    localparam int UDC_SLOTS = UDC_CHARS * UDC_ROWS;
    localparam int SLOT_AW   = $clog2(UDC_SLOTS);
    localparam int CLEAR_BIT = 7;
    localparam logic [DATA_W-1:0] BLANK = 8'h20;

    typedef enum logic [2:0] {
        AREA_FLASH,
        AREA_UDC_PTR,
        AREA_UDC_ROW,
        AREA_CTRL,
        AREA_CHAR
    } area_e;

    typedef struct packed {
        logic              sel_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_word_t;

    typedef struct packed {
        area_e             area;
        logic [DIG_AW-1:0] slot;
        logic [DATA_W-1:0] data;
    } wreq_t;

    function automatic area_e decode_area(logic sel_n, logic hi, logic lo);
        if (!sel_n)          return AREA_FLASH;
        case ({hi, lo})
            2'b00:   return AREA_UDC_PTR;
            2'b01:   return AREA_UDC_ROW;
            2'b10:   return AREA_CTRL;
            default: return AREA_CHAR;
        endcase
    endfunction

    function automatic logic [SLOT_AW-1:0] udc_slot(logic [UDC_AW-1:0] c,
                                                    logic [ROW_AW-1:0] r);
        return SLOT_AW'(int'(c) * UDC_ROWS + int'(r));
    endfunction
endpackage

// File: rtl/dispwr_sync.sv
module dispwr_sync
    import dispwr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       wr_n,
    input  host_word_t word,
    output logic       wr_pulse,
    output wreq_t      req
);
    localparam int W = 2 + $bits(host_word_t);
    localparam logic [W-1:0] IDLE = {1'b1, 1'b1, 1'b1, {(W-3){1'b0}}};

    typedef struct packed {
        logic       ce_n;
        logic       wr_n;
        host_word_t word;
    } bus_t;

    bus_t stg [STAGES];
    bus_t last;
    logic wr_prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stg[i] <= bus_t'(IDLE);
            else if (i == 0) stg[i] <= '{ce_n: ce_n, wr_n: wr_n, word: word};
            else             stg[i] <= stg[(i == 0) ? 0 : i - 1];
        end
    end

    assign last = stg[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b1;
        else     wr_prev <= last.wr_n;
    end

    assign wr_pulse  = last.wr_n && !wr_prev && !last.ce_n;
    assign req.area  = decode_area(last.word.sel_n, last.word.addr[4], last.word.addr[3]);
    assign req.slot  = last.word.addr[DIG_AW-1:0];
    assign req.data  = last.word.data;
endmodule

// File: rtl/dispwr_lockout.sv
module dispwr_lockout #(
    parameter int TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic ready
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (tick && cnt < LIMIT) cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == LIMIT);
endmodule

// File: rtl/dispwr_store.sv
module dispwr_store
    import dispwr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  wreq_t                    req,
    input  logic [UDC_AW-1:0]        rd_char,
    input  logic [ROW_AW-1:0]        rd_row,
    output logic [DIGITS-1:0]        flash_bits,
    output logic [DIGITS*DATA_W-1:0] char_flat,
    output logic [UDC_AW-1:0]        udc_ptr,
    output logic [DATA_W-1:0]        ctrl_word,
    output logic [ROW_W-1:0]         rd_bits
);
    logic [DATA_W-1:0] chars   [DIGITS];
    logic [ROW_W-1:0]  udc_mem [UDC_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            flash_bits <= '0;
            udc_ptr    <= '0;
            ctrl_word  <= '0;
            for (int d = 0; d < DIGITS; d++) chars[d] <= BLANK;
        end else if (we) begin
            case (req.area)
                AREA_FLASH:   flash_bits[req.slot] <= req.data[0];
                AREA_UDC_PTR: udc_ptr <= req.data[UDC_AW-1:0];
                AREA_CTRL: begin
                    ctrl_word <= req.data;
                    if (req.data[CLEAR_BIT])
                        for (int d = 0; d < DIGITS; d++) chars[d] <= BLANK;
                end
                AREA_CHAR:    chars[req.slot] <= req.data;
                default: ;
            endcase
        end
    end

    // glyph rows are never reset or cleared
    always_ff @(posedge clk) begin
        if (!rst && we && req.area == AREA_UDC_ROW && int'(req.slot) < UDC_ROWS)
            udc_mem[udc_slot(udc_ptr, req.slot)] <= req.data[ROW_W-1:0];
    end

    assign rd_bits = (int'(rd_row) < UDC_ROWS) ? udc_mem[udc_slot(rd_char, rd_row)] : '0;

    for (genvar d = 0; d < DIGITS; d++) begin : g_flat
        assign char_flat[d*DATA_W +: DATA_W] = chars[d];
    end
endmodule

// File: rtl/dispwr_front.sv
module dispwr_front
    import dispwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_TICKS  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        disp_tick,
    input  logic        host_ce_n,
    input  logic        host_wr_n,
    input  logic        host_sel_n,
    input  logic [4:0]  host_addr,
    input  logic [7:0]  host_data,
    input  logic [3:0]  scan_udc_char,
    input  logic [2:0]  scan_udc_row,
    output logic [7:0]  flash_bits,
    output logic [63:0] char_flat,
    output logic [3:0]  udc_ptr,
    output logic [7:0]  ctrl_word,
    output logic [4:0]  scan_udc_bits
);
    host_word_t word;
    wreq_t      wreq;
    logic       wr_pulse;
    logic       access_ok;
    logic       wr_go;
    area_e      go_area;

    assign word    = '{sel_n: host_sel_n, addr: host_addr, data: host_data};
    assign wr_go   = wr_pulse && access_ok;
    assign go_area = wreq.area;

    dispwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (host_ce_n),
        .wr_n     (host_wr_n),
        .word     (word),
        .wr_pulse (wr_pulse),
        .req      (wreq)
    );

    dispwr_lockout #(.TICKS(LOCK_TICKS)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .tick  (disp_tick),
        .ready (access_ok)
    );

    dispwr_store u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_go),
        .req        (wreq),
        .rd_char    (scan_udc_char),
        .rd_row     (scan_udc_row),
        .flash_bits (flash_bits),
        .char_flat  (char_flat),
        .udc_ptr    (udc_ptr),
        .ctrl_word  (ctrl_word),
        .rd_bits    (scan_udc_bits)
    );
endmodule

// File: rtl/dispwr_checker.sv
module dispwr_checker
    import dispwr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        access_ok,
    input logic        wr_go,
    input area_e       go_area,
    input logic [7:0]  flash_bits,
    input logic [63:0] char_flat,
    input logic [3:0]  udc_ptr,
    input logic [7:0]  ctrl_word
);
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flash_bits == '0 && ctrl_word == '0 && udc_ptr == '0
                        && char_flat == {8{BLANK}}));

    p_lockout_r9: assert property (@(posedge clk) disable iff (rst)
        !access_ok |=> ($stable(ctrl_word) && $stable(flash_bits)
                        && $stable(char_flat) && $stable(udc_ptr)));

    p_flash_only_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && go_area == AREA_FLASH) |=> $stable(flash_bits));

    p_ptr_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && go_area == AREA_UDC_PTR) |=> $stable(udc_ptr));

    p_ctrl_only_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && go_area == AREA_CTRL) |=> $stable(ctrl_word));

    p_clear_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_go && go_area == AREA_CTRL) |=>
            (!ctrl_word[CLEAR_BIT] || char_flat == {8{BLANK}}));
endmodule

bind dispwr_front dispwr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .access_ok  (access_ok),
    .wr_go      (wr_go),
    .go_area    (go_area),
    .flash_bits (flash_bits),
    .char_flat  (char_flat),
    .udc_ptr    (udc_ptr),
    .ctrl_word  (ctrl_word)
);

// File: tb/dispwr_front_bench.sv
module dispwr_front_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_tick = 1'b0;
    logic        host_ce_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic        host_sel_n = 1'b1;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_data = '0;
    logic [3:0]  scan_udc_char = '0;
    logic [2:0]  scan_udc_row = '0;
    logic [7:0]  flash_bits;
    logic [63:0] char_flat;
    logic [3:0]  udc_ptr;
    logic [7:0]  ctrl_word;
    logic [4:0]  scan_udc_bits;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_chr [8];

    always #4 clk = ~clk;

    dispwr_front u_dispwr_front (.*);

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] exp_flat();
        logic [63:0] v;
        for (int d = 0; d < 8; d++) v[d*8 +: 8] = exp_chr[d];
        return v;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) disp_tick = 1'b1;
        @(negedge clk) disp_tick = 1'b0;
    endtask

    task automatic wr(logic sel_n, logic [4:0] a, logic [7:0] d, logic ce_n = 1'b0);
        @(negedge clk);
        host_sel_n = sel_n; host_addr = a; host_data = d; host_ce_n = ce_n;
        cyc(3); host_wr_n = 1'b0;
        cyc(3); host_wr_n = 1'b1;
        cyc(5); host_ce_n = 1'b1;
        cyc(2);
    endtask

    task automatic do_reset(bit unlock);
        @(negedge clk) rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        for (int d = 0; d < 8; d++) exp_chr[d] = 8'h20;
        if (unlock) repeat (3) tick();
    endtask

    function automatic logic [4:0] row_pat(int c, int r);
        return 5'((c * 7 + r * 3 + 1) & 31);
    endfunction

    task automatic read_row(int c, int r);
        @(negedge clk);
        scan_udc_char = 4'(c); scan_udc_row = 3'(r);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        cyc(1);
        check("R8 flash", {56'b0, flash_bits}, 64'h0);
        check("R8 ctrl",  {56'b0, ctrl_word}, 64'h0);
        check("R8 ptr",   {60'b0, udc_ptr}, 64'h0);
        check("R8 chars", char_flat, exp_flat());
    endtask

    task automatic t_lockout();
        do_reset(1'b0);
        wr(1'b1, 5'b10000, 8'h05);
        check("R9 no ticks", {56'b0, ctrl_word}, 64'h0);
        tick(); tick();
        wr(1'b1, 5'b10000, 8'h05);
        check("R9 two ticks", {56'b0, ctrl_word}, 64'h0);
        tick();
        wr(1'b1, 5'b10000, 8'h05);
        check("R9 three ticks", {56'b0, ctrl_word}, 64'h05);
    endtask

    task automatic t_char();
        wr(1'b1, 5'b11000, 8'h41); exp_chr[0] = 8'h41;
        wr(1'b1, 5'b11111, 8'h8C); exp_chr[7] = 8'h8C;
        wr(1'b1, 5'b11011, 8'h7A); exp_chr[3] = 8'h7A;
        check("R5 chars", char_flat, exp_flat());
    endtask

    task automatic t_flash();
        wr(1'b0, 5'b11000, 8'hFF);
        wr(1'b0, 5'b11011, 8'h01);
        wr(1'b0, 5'b00111, 8'h03);
        wr(1'b0, 5'b10101, 8'hFE);
        check("R2 flash", {56'b0, flash_bits}, 64'h89);
        check("R2 chars untouched", char_flat, exp_flat());
    endtask

    task automatic t_ce();
        wr(1'b1, 5'b10000, 8'h77, 1'b1);
        check("R1 ce high ctrl", {56'b0, ctrl_word}, 64'h05);
        wr(1'b1, 5'b11010, 8'h55, 1'b1);
        check("R1 ce high chars", char_flat, exp_flat());
    endtask

    task automatic t_ctrl();
        wr(1'b1, 5'b10110, 8'h2A);
        check("R6 ctrl", {56'b0, ctrl_word}, 64'h2A);
    endtask

    task automatic t_udc();
        wr(1'b1, 5'b00011, 8'hF5);
        check("R3 ptr", {60'b0, udc_ptr}, 64'h5);
        for (int r = 0; r < 7; r++) wr(1'b1, 5'(8 + r), {3'b111, row_pat(5, r)});
        wr(1'b1, 5'b01111, 8'h1F);
        wr(1'b1, 5'b00000, 8'h09);
        wr(1'b1, 5'b01000, 8'h0A);
        for (int r = 0; r < 7; r++) begin
            read_row(5, r);
            check("R4 row", {59'b0, scan_udc_bits}, {59'b0, row_pat(5, r)});
        end
        read_row(5, 7);
        check("R10 row7", {59'b0, scan_udc_bits}, 64'h0);
        read_row(9, 0);
        check("R4 second glyph", {59'b0, scan_udc_bits}, 64'h0A);
    endtask

    task automatic t_clear();
        wr(1'b1, 5'b10000, 8'h83);
        for (int d = 0; d < 8; d++) exp_chr[d] = 8'h20;
        check("R7 chars blank", char_flat, exp_flat());
        check("R7 ctrl kept", {56'b0, ctrl_word}, 64'h83);
        check("R7 flash kept", {56'b0, flash_bits}, 64'h89);
        read_row(5, 2);
        check("R10 glyph kept on clear", {59'b0, scan_udc_bits}, {59'b0, row_pat(5, 2)});
    endtask

    task automatic t_reset_again();
        do_reset(1'b1);
        check("R8 flash again", {56'b0, flash_bits}, 64'h0);
        check("R8 ctrl again", {56'b0, ctrl_word}, 64'h0);
        read_row(5, 6);
        check("R10 glyph kept on reset", {59'b0, scan_udc_bits}, {59'b0, row_pat(5, 6)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lockout();
        t_char();
        t_flash();
        t_ce();
        t_ctrl();
        t_udc();
        t_clear();
        t_reset_again();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule